// File: doc/BRIEF.md
# Thread Patch Scheduler for Compute and Intersection Cores

This block runs one patch of threads across a small group of general compute cores and a larger group of ray-intersection cores. Each thread has an index within the patch and a pixel number derived from a base pixel that arrives with the patch. Idle compute cores are handed ready threads one at a time. A running thread may ask to trace a ray. The thread then leaves its compute core and waits in a trace queue, and the freed core can take other work on a later cycle. Intersection cores take threads from the trace queue. When an intersection core reports completion, its thread goes back into the ready queue and resumes at the program counter it saved when it left its compute core.

Cores are modelled only by their control ports. The scheduler emits a one-cycle start pulse with the thread index, pixel and start PC. A core holds a trace, finish or done request until the scheduler acknowledges it. When every thread in the patch has finished, the scheduler raises a one-cycle completion pulse and can accept the next patch.

Top module: `patch_dispatcher`

## Requirements
- R1: During and straight after reset, `patch_ready` is 1 and `patch_done`, `cc_start`, `ic_start`, `cc_ack` and `ic_ack` are all 0.
- R2: A patch is taken only while `patch_ready` is 1. Once a patch is taken, `patch_ready` stays 0 until the completion pulse, and `patch_valid` or a new base pixel applied during that time has no effect on the pixel numbers handed out.
- R3: The thread with index t receives pixel number (base + t) mod 2^PIX_W.
- R4: The first launch of a thread starts at PC 0. A thread relaunched after a trace starts at the `cc_resume_pc` that its compute core presented on the acknowledged trace request.
- R5: At most one compute start per cycle. It goes to the lowest-numbered idle compute core, and threads leave the ready queue in FIFO order. On acceptance the queue is loaded with indices 0 to N-1 in ascending order, and returning threads join at the tail in the order their done requests are acknowledged.
- R6: An acknowledged trace frees its compute core and appends the thread to the trace queue. No thread is lost or duplicated: the threads queued, on cores and retired always add up to N.
- R7: At most one intersection start per cycle. It goes to the lowest-numbered idle intersection core, and threads are taken in the order their trace requests were acknowledged.
- R8: In each cycle, exactly one request is acknowledged from each group when any busy core in that group has one pending: the lowest-numbered busy compute core with `cc_trace` or `cc_fin` high, and likewise the lowest-numbered busy intersection core with `ic_done` high. A compute request with both `cc_trace` and `cc_fin` high counts as a trace.
- R9: `patch_done` is a one-cycle pulse. It is registered on the clock edge that acknowledges the N-th finish, and `patch_ready` returns to 1 in the same cycle.
- R10: A core is never started while it is already busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| patch_valid | input | 1 | Offer of a new patch |
| patch_base_pix | input | PIX_W | Pixel number of thread 0 of the offered patch |
| patch_ready | output | 1 | Idle, a patch offer is taken this cycle |
| patch_done | output | 1 | One-cycle pulse when all threads have finished |
| cc_start | output | NUM_CC | Per compute core, one-cycle launch pulse |
| cc_tid | output | NUM_CC*TID_W | Per compute core, thread index of the current launch |
| cc_pix | output | NUM_CC*PIX_W | Per compute core, pixel number of the current thread |
| cc_pc | output | NUM_CC*PC_W | Per compute core, start PC of the current launch |
| cc_trace | input | NUM_CC | Per compute core, held trace request |
| cc_fin | input | NUM_CC | Per compute core, held finish request |
| cc_resume_pc | input | NUM_CC*PC_W | Per compute core, PC to resume at after a trace |
| cc_ack | output | NUM_CC | Per compute core, request taken at the coming edge |
| ic_start | output | NUM_IC | Per intersection core, one-cycle launch pulse |
| ic_tid | output | NUM_IC*TID_W | Per intersection core, thread index being traced |
| ic_done | input | NUM_IC | Per intersection core, held completion request |
| ic_ack | output | NUM_IC | Per intersection core, completion taken at the coming edge |

## Verification
The assertions assume that cores raise requests only while they hold a thread, keep each request up until it is acknowledged, and never raise trace and finish together. The bench core models start a countdown on each launch pulse, raise a single request when it expires, drop it on the cycle after the acknowledge, and take every resume PC from a per-thread formula. A compute thread's trace count and a core's delay come from the thread index, so acknowledges collide and the ready and trace queues fill and drain in interleaved order. Two patches are run, the second with a base pixel that wraps.

// File: rtl/pd_pkg.sv
// Shared types for the patch dispatcher.
// Assumes nothing beyond a 2-bit per-thread state code.
package pd_pkg;
    typedef enum logic [1:0] {
        TH_READY   = 2'd0,
        TH_RUNNING = 2'd1,
        TH_TRACING = 2'd2,
        TH_DONE    = 2'd3
    } th_state_e;
endpackage

// File: rtl/pd_pick_low.sv
// Fixed-priority picker: grants the lowest set bit of req.
// Assumes N >= 2. Purely combinational.
module pd_pick_low #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Scan from the top so the lowest requester is assigned last and wins.
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = i[IW-1:0];
                any    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/pd_tid_fifo.sv
// FIFO of thread indices, DEPTH a power of two equal to the thread count.
// load_all fills it with 0..DEPTH-1 in one cycle. Assumes the caller never
// pushes when full or pops when empty (guaranteed by thread conservation).
module pd_tid_fifo #(
    parameter int DEPTH = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_all,
    input  logic          push,
    input  logic [AW-1:0] push_id,
    input  logic          pop,
    output logic [AW-1:0] head_id,
    output logic          empty,
    output logic [AW:0]   level
);
    logic [AW-1:0] mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;

    // Storage writes: bulk load of all indices, or a single push.
    always_ff @(posedge clk) begin
        if (load_all) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= i[AW-1:0];
        end else if (push) begin
            mem[wr_ptr] <= push_id;
        end
    end

    // Pointer and occupancy upkeep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else if (load_all) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= (AW+1)'(DEPTH);
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            level <= level + (AW+1)'(push) - (AW+1)'(pop);
        end
    end

    assign head_id = mem[rd_ptr];
    assign empty   = (level == '0);
endmodule

// File: rtl/patch_dispatcher.sv
// Patch dispatcher: schedules one patch of NUM_THREADS threads onto NUM_CC
// compute cores and NUM_IC intersection cores. Threads move ready queue ->
// compute core -> (trace queue -> intersection core -> ready queue)* -> done.
// Assumes cores hold each request until acked, and raise requests only
// while holding a thread. NUM_THREADS must be a power of two.
module patch_dispatcher #(
    parameter int NUM_THREADS = 32,
    parameter int NUM_CC      = 4,
    parameter int NUM_IC      = 8,
    parameter int PIX_W       = 16,
    parameter int PC_W        = 12,
    localparam int TID_W      = $clog2(NUM_THREADS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      patch_valid,
    input  logic [PIX_W-1:0]          patch_base_pix,
    output logic                      patch_ready,
    output logic                      patch_done,
    output logic [NUM_CC-1:0]         cc_start,
    output logic [NUM_CC*TID_W-1:0]   cc_tid,
    output logic [NUM_CC*PIX_W-1:0]   cc_pix,
    output logic [NUM_CC*PC_W-1:0]    cc_pc,
    input  logic [NUM_CC-1:0]         cc_trace,
    input  logic [NUM_CC-1:0]         cc_fin,
    input  logic [NUM_CC*PC_W-1:0]    cc_resume_pc,
    output logic [NUM_CC-1:0]         cc_ack,
    output logic [NUM_IC-1:0]         ic_start,
    output logic [NUM_IC*TID_W-1:0]   ic_tid,
    input  logic [NUM_IC-1:0]         ic_done,
    output logic [NUM_IC-1:0]         ic_ack
);
    import pd_pkg::*;

    localparam int CCW = $clog2(NUM_CC);
    localparam int ICW = $clog2(NUM_IC);
    localparam int CNT_W = TID_W + 1;

    logic                     active;
    logic [PIX_W-1:0]         base_q;
    logic [CNT_W-1:0]         retired;
    logic [NUM_CC-1:0]        cc_busy;
    logic [NUM_IC-1:0]        ic_busy;
    logic [TID_W-1:0]         cc_thr [NUM_CC];
    logic [TID_W-1:0]         ic_thr [NUM_IC];
    logic [PIX_W-1:0]         cc_pix_q [NUM_CC];
    logic [PC_W-1:0]          cc_pc_q [NUM_CC];
    logic [NUM_THREADS-1:0][1:0] th_st;
    logic [PC_W-1:0]          th_pc [NUM_THREADS];

    logic accept;
    assign accept      = patch_valid && !active;
    assign patch_ready = !active;

    // Ready and trace queues.
    logic             rq_push, rq_pop, rq_empty, tq_push, tq_pop, tq_empty;
    logic [TID_W-1:0] rq_in, rq_head, tq_in, tq_head;
    logic [TID_W:0]   rq_lvl, tq_lvl;

    pd_tid_fifo #(.DEPTH(NUM_THREADS)) u_rq (
        .clk(clk), .rst_n(rst_n), .load_all(accept),
        .push(rq_push), .push_id(rq_in), .pop(rq_pop),
        .head_id(rq_head), .empty(rq_empty), .level(rq_lvl));

    pd_tid_fifo #(.DEPTH(NUM_THREADS)) u_tq (
        .clk(clk), .rst_n(rst_n), .load_all(1'b0),
        .push(tq_push), .push_id(tq_in), .pop(tq_pop),
        .head_id(tq_head), .empty(tq_empty), .level(tq_lvl));

    // Arbiters: free compute core, compute request, free ic core, ic return.
    logic [NUM_CC-1:0] cc_sel;
    logic [CCW-1:0]    cc_sel_idx, ev_idx;
    logic              cc_free_any, ev_any;
    logic [NUM_IC-1:0] ic_sel;
    logic [ICW-1:0]    ic_sel_idx, ret_idx;
    logic              ic_free_any, ret_any;

    pd_pick_low #(.N(NUM_CC)) u_cc_free (
        .req(~cc_busy), .gnt(cc_sel), .idx(cc_sel_idx), .any(cc_free_any));
    pd_pick_low #(.N(NUM_CC)) u_cc_evt (
        .req((cc_trace | cc_fin) & cc_busy), .gnt(cc_ack), .idx(ev_idx), .any(ev_any));
    pd_pick_low #(.N(NUM_IC)) u_ic_free (
        .req(~ic_busy), .gnt(ic_sel), .idx(ic_sel_idx), .any(ic_free_any));
    pd_pick_low #(.N(NUM_IC)) u_ic_ret (
        .req(ic_done & ic_busy), .gnt(ic_ack), .idx(ret_idx), .any(ret_any));

    logic             cc_disp, ic_disp, ev_trace, ev_fin;
    logic [TID_W-1:0] ev_tid, ret_tid;
    logic [PC_W-1:0]  ev_pc;

    // Decode of this cycle's dispatches and acknowledged events.
    always_comb begin
        cc_disp  = active && cc_free_any && !rq_empty;
        ic_disp  = ic_free_any && !tq_empty;
        ev_tid   = cc_thr[ev_idx];
        ev_pc    = cc_resume_pc[ev_idx*PC_W +: PC_W];
        ev_trace = ev_any && cc_trace[ev_idx];
        ev_fin   = ev_any && !cc_trace[ev_idx];
        ret_tid  = ic_thr[ret_idx];
        rq_pop   = cc_disp;
        rq_push  = ret_any;
        rq_in    = ret_tid;
        tq_pop   = ic_disp;
        tq_push  = ev_trace;
        tq_in    = ev_tid;
    end

    // Patch lifecycle: accept, retire count, completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active     <= 1'b0;
            base_q     <= '0;
            retired    <= '0;
            patch_done <= 1'b0;
        end else begin
            patch_done <= 1'b0;
            if (accept) begin
                active  <= 1'b1;
                base_q  <= patch_base_pix;
                retired <= '0;
            end else if (ev_fin) begin
                retired <= retired + 1'b1;
                if (retired == CNT_W'(NUM_THREADS - 1)) begin
                    active     <= 1'b0;
                    patch_done <= 1'b1;
                end
            end
        end
    end

    // Per-thread state and saved resume PC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int t = 0; t < NUM_THREADS; t++) begin
                th_st[t] <= TH_DONE;
                th_pc[t] <= '0;
            end
        end else if (accept) begin
            for (int t = 0; t < NUM_THREADS; t++) begin
                th_st[t] <= TH_READY;
                th_pc[t] <= '0;
            end
        end else begin
            if (cc_disp)  th_st[rq_head] <= TH_RUNNING;
            if (ev_trace) begin
                th_st[ev_tid] <= TH_TRACING;
                th_pc[ev_tid] <= ev_pc;
            end
            if (ev_fin)   th_st[ev_tid]  <= TH_DONE;
            if (ret_any)  th_st[ret_tid] <= TH_READY;
        end
    end

    // Compute core slots: occupancy, launch pulse and launch fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_busy  <= '0;
            cc_start <= '0;
            for (int k = 0; k < NUM_CC; k++) begin
                cc_thr[k]   <= '0;
                cc_pix_q[k] <= '0;
                cc_pc_q[k]  <= '0;
            end
        end else begin
            cc_busy  <= (cc_busy & ~cc_ack) | (cc_disp ? cc_sel : '0);
            cc_start <= cc_disp ? cc_sel : '0;
            if (cc_disp) begin
                cc_thr[cc_sel_idx]   <= rq_head;
                cc_pix_q[cc_sel_idx] <= base_q + PIX_W'(rq_head);
                cc_pc_q[cc_sel_idx]  <= th_pc[rq_head];
            end
        end
    end

    // Intersection core slots: occupancy, launch pulse and thread index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ic_busy  <= '0;
            ic_start <= '0;
            for (int k = 0; k < NUM_IC; k++) ic_thr[k] <= '0;
        end else begin
            ic_busy  <= (ic_busy & ~ic_ack) | (ic_disp ? ic_sel : '0);
            ic_start <= ic_disp ? ic_sel : '0;
            if (ic_disp) ic_thr[ic_sel_idx] <= tq_head;
        end
    end

    // Flatten per-core fields onto the output buses.
    for (genvar k = 0; k < NUM_CC; k++) begin : g_cc_out
        assign cc_tid[k*TID_W +: TID_W] = cc_thr[k];
        assign cc_pix[k*PIX_W +: PIX_W] = cc_pix_q[k];
        assign cc_pc[k*PC_W +: PC_W]    = cc_pc_q[k];
    end
    for (genvar k = 0; k < NUM_IC; k++) begin : g_ic_out
        assign ic_tid[k*TID_W +: TID_W] = ic_thr[k];
    end
endmodule

// File: rtl/pd_checker.sv
// Protocol checker for patch_dispatcher, attached by bind below.
// Assumes the core-side request rules stated in the brief.
module pd_checker #(
    parameter int NUM_THREADS = 32,
    parameter int NUM_CC      = 4,
    parameter int NUM_IC      = 8,
    parameter int PIX_W       = 16,
    parameter int TID_W       = 5
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        active,
    input logic                        patch_ready,
    input logic                        patch_done,
    input logic [PIX_W-1:0]            base_q,
    input logic [NUM_CC-1:0]           cc_start,
    input logic [NUM_CC-1:0]           cc_busy,
    input logic [NUM_CC-1:0]           cc_ack,
    input logic [NUM_IC-1:0]           ic_start,
    input logic [NUM_IC-1:0]           ic_busy,
    input logic [NUM_IC-1:0]           ic_ack,
    input logic                        cc_disp,
    input logic [TID_W-1:0]            rq_head,
    input logic [NUM_THREADS-1:0][1:0] th_st,
    input logic [TID_W:0]              rq_lvl,
    input logic [TID_W:0]              tq_lvl,
    input logic [TID_W:0]              retired
);
    import pd_pkg::*;

    a_r5_one_cc_start: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cc_start));
    a_r7_one_ic_start: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ic_start));
    a_r10_cc_start_free: assert property (@(posedge clk) disable iff (!rst_n)
        |cc_start |=> ((cc_start & $past(cc_busy)) == '0));
    a_r10_ic_start_free: assert property (@(posedge clk) disable iff (!rst_n)
        |ic_start |=> ((ic_start & $past(ic_busy)) == '0));
    a_r8_cc_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cc_ack) && ((cc_ack & ~cc_busy) == '0));
    a_r8_ic_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ic_ack) && ((ic_ack & ~ic_busy) == '0));
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        patch_done |=> !patch_done);
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        patch_done |-> patch_ready);
    a_r2_base_held: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> $stable(base_q));
    a_r5_dispatch_ready: assert property (@(posedge clk) disable iff (!rst_n)
        cc_disp |-> (th_st[rq_head] == TH_READY));
    a_r6_conserve: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (32'(rq_lvl) + 32'(tq_lvl) + $countones(cc_busy)
                    + $countones(ic_busy) + 32'(retired) == NUM_THREADS));
endmodule

bind patch_dispatcher pd_checker #(
    .NUM_THREADS(NUM_THREADS), .NUM_CC(NUM_CC), .NUM_IC(NUM_IC),
    .PIX_W(PIX_W), .TID_W(TID_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .active(active), .patch_ready(patch_ready),
    .patch_done(patch_done), .base_q(base_q), .cc_start(cc_start),
    .cc_busy(cc_busy), .cc_ack(cc_ack), .ic_start(ic_start),
    .ic_busy(ic_busy), .ic_ack(ic_ack), .cc_disp(cc_disp),
    .rq_head(rq_head), .th_st(th_st), .rq_lvl(rq_lvl), .tq_lvl(tq_lvl),
    .retired(retired)
);

// File: tb/tb_patch_dispatcher.sv
// Self-checking bench: behavioural core models drive two full patches.
module tb_patch_dispatcher;
    localparam int NT = 32, NC = 4, NI = 8, PW = 16, CW = 12, TW = 5;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic             patch_valid = 1'b0;
    logic [PW-1:0]    patch_base_pix = '0;
    logic             patch_ready, patch_done;
    logic [NC-1:0]    cc_start, cc_ack;
    logic [NC*TW-1:0] cc_tid;
    logic [NC*PW-1:0] cc_pix;
    logic [NC*CW-1:0] cc_pc;
    logic [NC-1:0]    cc_trace = '0, cc_fin = '0;
    logic [NC*CW-1:0] cc_resume_pc;
    logic [NI-1:0]    ic_start, ic_ack;
    logic [NI*TW-1:0] ic_tid;
    logic [NI-1:0]    ic_done = '0;

    patch_dispatcher dut (
        .clk(clk), .rst_n(rst_n), .patch_valid(patch_valid),
        .patch_base_pix(patch_base_pix), .patch_ready(patch_ready),
        .patch_done(patch_done), .cc_start(cc_start), .cc_tid(cc_tid),
        .cc_pix(cc_pix), .cc_pc(cc_pc), .cc_trace(cc_trace), .cc_fin(cc_fin),
        .cc_resume_pc(cc_resume_pc), .cc_ack(cc_ack), .ic_start(ic_start),
        .ic_tid(ic_tid), .ic_done(ic_done), .ic_ack(ic_ack));

    int checks = 0, errors = 0;
    int exp_rq[$], exp_tq[$];
    int exp_pc[NT], trace_left[NT];
    int cc_cur[NC], cc_tmr[NC], ic_cur[NI], ic_tmr[NI];
    logic [CW-1:0] res_pc[NC];
    logic [NC-1:0] bm_cc_busy, pend_cc;
    logic [NI-1:0] bm_ic_busy, pend_ic;
    int base, fins;

    always_comb for (int k = 0; k < NC; k++) cc_resume_pc[k*CW +: CW] = res_pc[k];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int lowest(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return -1;
    endfunction

    // One negedge step of the core models and scoreboard.
    task automatic step(input bit spurious);
        int tid, e;
        @(negedge clk);
        if (spurious) chk(patch_ready == 1'b0, "R2 ready low in patch", patch_ready, 0);
        // Launches from the edge just passed.
        for (int k = 0; k < NC; k++) if (cc_start[k]) begin
            chk(k == lowest({4'b0, ~bm_cc_busy}), "R5/R10 lowest idle cc", k, lowest({4'b0, ~bm_cc_busy}));
            e = (exp_rq.size() > 0) ? exp_rq.pop_front() : -1;
            tid = int'(cc_tid[k*TW +: TW]);
            chk(tid == e, "R5 ready order", tid, e);
            chk(int'(cc_pix[k*PW +: PW]) == ((base + tid) & 16'hFFFF), "R3 pixel",
                int'(cc_pix[k*PW +: PW]), (base + tid) & 16'hFFFF);
            chk(int'(cc_pc[k*CW +: CW]) == exp_pc[tid], "R4 start pc",
                int'(cc_pc[k*CW +: CW]), exp_pc[tid]);
            cc_cur[k] = tid;
            cc_tmr[k] = tid % 3 + 1;
        end
        for (int k = 0; k < NI; k++) if (ic_start[k]) begin
            chk(k == lowest(~bm_ic_busy), "R7/R10 lowest idle ic", k, lowest(~bm_ic_busy));
            e = (exp_tq.size() > 0) ? exp_tq.pop_front() : -1;
            tid = int'(ic_tid[k*TW +: TW]);
            chk(tid == e, "R7 trace order", tid, e);
            ic_cur[k] = tid;
            ic_tmr[k] = tid % 4 + 1;
        end
        // Acks taken at the edge just passed.
        for (int k = 0; k < NC; k++) if (pend_cc[k]) begin
            if (cc_trace[k]) begin
                exp_tq.push_back(cc_cur[k]);
                exp_pc[cc_cur[k]] = int'(res_pc[k]);
                trace_left[cc_cur[k]]--;
            end else fins++;
            cc_trace[k] = 1'b0;
            cc_fin[k] = 1'b0;
            bm_cc_busy[k] = 1'b0;
        end
        for (int k = 0; k < NI; k++) if (pend_ic[k]) begin
            exp_rq.push_back(ic_cur[k]);
            ic_done[k] = 1'b0;
            bm_ic_busy[k] = 1'b0;
        end
        bm_cc_busy = bm_cc_busy | cc_start;
        bm_ic_busy = bm_ic_busy | ic_start;
        chk(patch_done == (pend_cc != 0 && fins == NT), "R9 done pulse",
            patch_done, (pend_cc != 0 && fins == NT));
        if (patch_done) chk(patch_ready == 1'b1, "R9 ready after done", patch_ready, 1);
        // Core countdowns raise requests.
        for (int k = 0; k < NC; k++)
            if (bm_cc_busy[k] && !cc_trace[k] && !cc_fin[k] && cc_tmr[k] > 0) begin
                cc_tmr[k]--;
                if (cc_tmr[k] == 0) begin
                    if (trace_left[cc_cur[k]] > 0) begin
                        res_pc[k] = CW'(cc_cur[k] * 37 + trace_left[cc_cur[k]] * 501);
                        cc_trace[k] = 1'b1;
                    end else cc_fin[k] = 1'b1;
                end
            end
        for (int k = 0; k < NI; k++)
            if (bm_ic_busy[k] && !ic_done[k] && ic_tmr[k] > 0) begin
                ic_tmr[k]--;
                if (ic_tmr[k] == 0) ic_done[k] = 1'b1;
            end
        #1;
        chk(cc_ack == ((cc_trace | cc_fin) & -(cc_trace | cc_fin)), "R8 cc ack lowest",
            cc_ack, (cc_trace | cc_fin) & -(cc_trace | cc_fin));
        chk(ic_ack == (ic_done & -ic_done), "R8 ic ack lowest", ic_ack, ic_done & -ic_done);
        pend_cc = cc_ack;
        pend_ic = ic_ack;
    endtask

    task automatic run_patch(input int b, output bit ok);
        int n;
        @(negedge clk);
        chk(patch_ready == 1'b1, "R2 ready before patch", patch_ready, 1);
        patch_valid = 1'b1;
        patch_base_pix = PW'(b);
        @(negedge clk);
        patch_valid = 1'b0;
        base = b;
        fins = 0;
        exp_rq.delete();
        exp_tq.delete();
        for (int t = 0; t < NT; t++) begin
            exp_rq.push_back(t);
            exp_pc[t] = 0;
            trace_left[t] = t % 3;
        end
        chk(patch_ready == 1'b0, "R2 patch taken", patch_ready, 0);
        n = 0;
        ok = 1'b0;
        while (n < 20000) begin
            // Spurious offer with another base during the patch (R2).
            if (n >= 5 && n < 9) begin
                patch_valid = 1'b1;
                patch_base_pix = PW'(b + 1000);
            end else patch_valid = 1'b0;
            step(n >= 5 && n < 9);
            n++;
            if (patch_done) begin ok = 1'b1; break; end
        end
        patch_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            step(1'b0);
            chk(cc_start == 0 && patch_ready == 1'b1, "R9 idle after done", cc_start, 0);
        end
    endtask

    initial begin
        bit ok;
        bm_cc_busy = '0; bm_ic_busy = '0; pend_cc = '0; pend_ic = '0;
        for (int k = 0; k < NC; k++) res_pc[k] = '0;
        repeat (3) @(negedge clk);
        chk(patch_ready == 1'b1 && patch_done == 1'b0, "R1 reset status", {patch_ready, patch_done}, 2);
        chk(cc_start == 0 && ic_start == 0 && cc_ack == 0 && ic_ack == 0, "R1 reset quiet",
            {cc_start, ic_start}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(patch_ready == 1'b1 && cc_start == 0, "R1 after reset", patch_ready, 1);
        run_patch(100, ok);
        chk(ok, "R6 first patch completes", ok, 1);
        run_patch(16'hFFF0, ok);
        chk(ok, "R6 wrapping patch completes", ok, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule